// File: doc/BRIEF.md
# Windowed Address Translator

This block maps a request address from a local system bus into a PCI-style address space. It holds a small set of translation windows, by default six. Each window has a base address, a high address, a translation vector, a space-type flag (memory or I/O) and an enable bit. Each window covers a contiguous span whose size is a power of two, and its base is aligned to that size. Every request address is compared against all enabled windows at the same time. On a hit, the address bits inside the window are kept and the bits above them are taken from that window's translation vector. The result is then forced to a doubleword (8-byte) boundary.

Software or a neighbouring controller loads the windows through a plain write port. Each write gives a window index, a field select, a data word and a strobe. Lookups are registered: a request strobe returns its answer one clock later, together with a one-cycle valid pulse.

A small two-state machine sequences the response.
- In `S_IDLE`, no response is being presented.
- In `S_EMIT`, the registered result is presented with `rsp_valid` high.
- Transitions:
  - `S_IDLE -> S_EMIT` on a request strobe.
  - `S_EMIT -> S_EMIT` on a back-to-back request.
  - `S_EMIT -> S_IDLE` when no request arrives.

Top module: `addr_xlat_top`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_hit`, `rsp_io` and `rsp_addr` are all 0, and every window is disabled, so any request misses.
- R2: A window matches a request address A only when its enable bit is 1 and base <= A <= high.
- R3: On a hit, let mask = high - base. `rsp_addr` = ((vector & ~mask) | (A & mask)) with bits [2:0] forced to 0, whatever the low bits of A were.
- R4: On a hit, `rsp_io` equals the matching window's space flag, where 1 means I/O space and 0 means memory space.
- R5: When several windows match, the window with the lowest index supplies the result.
- R6: When no window matches, `rsp_hit` is 0, `rsp_addr` is 0 and `rsp_io` is 0.
- R7: `rsp_valid` is high for exactly the one cycle after each cycle in which `req_valid` is high. The result outputs hold their values in cycles that follow no request.
- R8: Field select encoding is 0 = base, 1 = high, 2 = translation vector, 3 = control. In the control field, bit 0 is the enable bit and bit 1 is the I/O flag. A write with `cfg_win` >= number of windows changes nothing.
- R9: A register write is used by requests presented from the cycle after the write onward. A request presented in the same cycle as the write still uses the old contents.
- R10: A disabled window never matches, even when its base and high bounds contain the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Window register write strobe |
| cfg_win | input | 3 | Window index for the write |
| cfg_field | input | 2 | Field select (base, high, vector, control) |
| cfg_data | input | 32 | Write data |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Local bus request address |
| rsp_valid | output | 1 | One-cycle pulse marking a fresh result |
| rsp_addr | output | 32 | Translated, doubleword-aligned address |
| rsp_io | output | 1 | Space type of the hit window (1 = I/O) |
| rsp_hit | output | 1 | A window matched |

## Verification
The checks assume that every window is programmed with a power-of-two size and a base aligned to that size, so that high - base is a mask of contiguous low ones. The random stimulus builds each window from a size exponent and masks its base to that size before writing it. The stimulus places windows in a narrow address range so that overlaps and priority cases occur often. Requests are split between offsets inside chosen windows, addresses at the window edges and fully random addresses, so that both hits and misses are covered.

// File: rtl/addr_xlat_pkg.sv
package addr_xlat_pkg;

    // Field select codes for the register write port
    typedef enum logic [1:0] {
        FLD_BASE = 2'd0,
        FLD_HIGH = 2'd1,
        FLD_VEC  = 2'd2,
        FLD_CTRL = 2'd3
    } fld_sel_e;

    // Bit positions inside the control field
    localparam int CTRL_EN_BIT = 0;
    localparam int CTRL_IO_BIT = 1;

    // Response sequencing states
    typedef enum logic {
        S_IDLE = 1'b0,
        S_EMIT = 1'b1
    } rsp_state_e;

endpackage

// File: rtl/xlat_win_regs.sv
module xlat_win_regs
    import addr_xlat_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NWIN = 6,
    localparam int IW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [IW-1:0]       win,
    input  logic [1:0]          field,
    input  logic [AW-1:0]       data,
    output logic [NWIN-1:0][AW-1:0] base_q,
    output logic [NWIN-1:0][AW-1:0] high_q,
    output logic [NWIN-1:0][AW-1:0] vec_q,
    output logic [NWIN-1:0]     en_q,
    output logic [NWIN-1:0]     io_q
);

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        logic sel;
        assign sel = we && (win == IW'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[i] <= '0;
                high_q[i] <= '0;
                vec_q[i]  <= '0;
                en_q[i]   <= 1'b0;
                io_q[i]   <= 1'b0;
            end else if (sel) begin
                unique case (fld_sel_e'(field))
                    FLD_BASE: base_q[i] <= data;
                    FLD_HIGH: high_q[i] <= data;
                    FLD_VEC:  vec_q[i]  <= data;
                    FLD_CTRL: begin
                        en_q[i] <= data[CTRL_EN_BIT];
                        io_q[i] <= data[CTRL_IO_BIT];
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/xlat_win_match.sv
module xlat_win_match #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] high,
    input  logic [AW-1:0] vec,
    input  logic          en,
    output logic          hit,
    output logic [AW-1:0] xaddr
);

    logic [AW-1:0] span_mask;
    logic [AW-1:0] merged;

    always_comb begin
        span_mask = high - base;
        hit       = en && (addr >= base) && (addr <= high);
        merged    = (vec & ~span_mask) | (addr & span_mask);
        xaddr     = {merged[AW-1:3], 3'b000};
    end

endmodule

// File: rtl/xlat_prio_pick.sv
module xlat_prio_pick #(
    parameter int AW   = 32,
    parameter int NWIN = 6
) (
    input  logic [NWIN-1:0]         hits,
    input  logic [NWIN-1:0][AW-1:0] xaddrs,
    input  logic [NWIN-1:0]         ios,
    output logic                    any_hit,
    output logic [AW-1:0]           sel_addr,
    output logic                    sel_io
);

    always_comb begin
        any_hit  = 1'b0;
        sel_addr = '0;
        sel_io   = 1'b0;
        // Walk from the top so the lowest index is assigned last and wins
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any_hit  = 1'b1;
                sel_addr = xaddrs[i];
                sel_io   = ios[i];
            end
        end
    end

endmodule

// File: rtl/addr_xlat_top.sv
module addr_xlat_top
    import addr_xlat_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NWIN = 6,
    localparam int IW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [IW-1:0] cfg_win,
    input  logic [1:0]    cfg_field,
    input  logic [AW-1:0] cfg_data,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output logic          rsp_valid,
    output logic [AW-1:0] rsp_addr,
    output logic          rsp_io,
    output logic          rsp_hit
);

    logic [NWIN-1:0][AW-1:0] base_q, high_q, vec_q, xaddrs;
    logic [NWIN-1:0]         en_q, io_q, hits;
    logic                    any_hit, sel_io;
    logic [AW-1:0]           sel_addr;

    rsp_state_e state_q, state_d;

    xlat_win_regs #(.AW(AW), .NWIN(NWIN)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .win    (cfg_win),
        .field  (cfg_field),
        .data   (cfg_data),
        .base_q (base_q),
        .high_q (high_q),
        .vec_q  (vec_q),
        .en_q   (en_q),
        .io_q   (io_q)
    );

    for (genvar i = 0; i < NWIN; i++) begin : g_match
        xlat_win_match #(.AW(AW)) u_match (
            .addr  (req_addr),
            .base  (base_q[i]),
            .high  (high_q[i]),
            .vec   (vec_q[i]),
            .en    (en_q[i]),
            .hit   (hits[i]),
            .xaddr (xaddrs[i])
        );
    end

    xlat_prio_pick #(.AW(AW), .NWIN(NWIN)) u_pick (
        .hits     (hits),
        .xaddrs   (xaddrs),
        .ios      (io_q),
        .any_hit  (any_hit),
        .sel_addr (sel_addr),
        .sel_io   (sel_io)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (req_valid) state_d = S_EMIT;
            S_EMIT: state_d = req_valid ? S_EMIT : S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Result registers, loaded on each request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_addr <= '0;
            rsp_io   <= 1'b0;
            rsp_hit  <= 1'b0;
        end else if (req_valid) begin
            rsp_hit  <= any_hit;
            rsp_addr <= any_hit ? sel_addr : '0;
            rsp_io   <= any_hit && sel_io;
        end
    end

    assign rsp_valid = (state_q == S_EMIT);

endmodule

// File: rtl/addr_xlat_chk.sv
module addr_xlat_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          rsp_valid,
    input logic [AW-1:0] rsp_addr,
    input logic          rsp_io,
    input logic          rsp_hit
);

    // R7
    pulse_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R7
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R7
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_addr) && $stable(rsp_hit) && $stable(rsp_io)));

    // R6
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_addr == '0 && !rsp_io));

    // R3
    dword_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_addr[2:0] == 3'b000));

endmodule

bind addr_xlat_top addr_xlat_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .rsp_valid (rsp_valid),
    .rsp_addr  (rsp_addr),
    .rsp_io    (rsp_io),
    .rsp_hit   (rsp_hit)
);

// File: tb/addr_xlat_top_bench.sv
`timescale 1ns/1ps
module addr_xlat_top_bench;

    localparam int AW   = 32;
    localparam int NWIN = 6;
    localparam int IW   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_win = '0;
    logic [1:0]    cfg_field = '0;
    logic [AW-1:0] cfg_data = '0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_valid, rsp_io, rsp_hit;
    logic [AW-1:0] rsp_addr;

    int n_tests = 0;
    int n_fail  = 0;

    // Bench copy of window contents, kept from the writes it issues
    logic [AW-1:0] m_base [NWIN];
    logic [AW-1:0] m_high [NWIN];
    logic [AW-1:0] m_vec  [NWIN];
    logic          m_en   [NWIN];
    logic          m_io   [NWIN];

    always #10 clk = ~clk;

    addr_xlat_top #(.AW(AW), .NWIN(NWIN)) u_addr_xlat_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_win   (cfg_win),
        .cfg_field (cfg_field),
        .cfg_data  (cfg_data),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .rsp_valid (rsp_valid),
        .rsp_addr  (rsp_addr),
        .rsp_io    (rsp_io),
        .rsp_hit   (rsp_hit)
    );

    function automatic void expect_of(input logic [AW-1:0] a,
                                      output logic h, output logic [AW-1:0] xa,
                                      output logic io);
        h = 1'b0; xa = '0; io = 1'b0;
        for (int i = 0; i < NWIN; i++) begin
            if (!h && m_en[i] && a >= m_base[i] && a <= m_high[i]) begin
                logic [AW-1:0] mk;
                mk = m_high[i] - m_base[i];
                h  = 1'b1;
                xa = ((m_vec[i] & ~mk) | (a & mk)) & ~AW'(7);
                io = m_io[i];
            end
        end
    endfunction

    task automatic check(input string req, input logic [AW-1:0] act,
                         input logic [AW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_write(input int w, input int f, input logic [AW-1:0] d);
        if (w < NWIN) begin
            case (f)
                0: m_base[w] = d;
                1: m_high[w] = d;
                2: m_vec[w]  = d;
                default: begin m_en[w] = d[0]; m_io[w] = d[1]; end
            endcase
        end
    endtask

    task automatic wr(input int w, input int f, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_win = IW'(w); cfg_field = 2'(f); cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
        model_write(w, f, d);
    endtask

    task automatic set_win(input int w, input logic [AW-1:0] b, input int k,
                           input logic [AW-1:0] v, input logic en, input logic io);
        logic [AW-1:0] sz;
        sz = AW'(1) << k;
        wr(w, 0, b & ~(sz - 1));
        wr(w, 1, (b & ~(sz - 1)) + sz - 1);
        wr(w, 2, v);
        wr(w, 3, {30'd0, io, en});
    endtask

    task automatic lookup(input logic [AW-1:0] a, input string tag);
        logic h, io; logic [AW-1:0] xa;
        expect_of(a, h, xa, io);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R7 valid"}, AW'(rsp_valid), AW'(1));
        check({tag, " hit"}, AW'(rsp_hit), AW'(h));
        check({tag, " addr"}, rsp_addr, xa);
        check({tag, " io"}, AW'(rsp_io), AW'(io));
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NWIN; i++) begin
            m_base[i] = '0; m_high[i] = '0; m_vec[i] = '0; m_en[i] = 0; m_io[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 valid", AW'(rsp_valid), 0);
        check("R1 hit", AW'(rsp_hit), 0);
        check("R1 addr", rsp_addr, 0);
        lookup(32'h0000_0000, "R1 miss after reset");

        // R7: no request, no pulse and outputs held
        @(negedge clk);
        check("R7 idle valid", AW'(rsp_valid), 0);

        // Directed: window 2, 4 KiB at 0x10000, memory; window 0 overlaps, I/O
        set_win(2, 32'h0001_0000, 12, 32'hABCD_E000, 1, 0);
        lookup(32'h0001_0000, "R2 base edge");
        lookup(32'h0001_0FFF, "R3 high edge low bits cleared");
        lookup(32'h0001_1000, "R2 above high");
        lookup(32'h0000_FFFF, "R6 below base");
        lookup(32'h0001_0567, "R3 mid");
        set_win(0, 32'h0001_0000, 8, 32'h7700_0000, 1, 1);
        lookup(32'h0001_0010, "R5 overlap lowest wins R4 io");
        lookup(32'h0001_0200, "R5 only higher window");
        // R10: disable window 0
        wr(0, 3, 32'h2);
        lookup(32'h0001_0010, "R10 disabled ignored");
        // R8: out-of-range index changes nothing
        wr(6, 3, 32'h0); wr(7, 0, 32'h0);
        lookup(32'h0001_0010, "R8 bad index");
        // R9: write and request in the same cycle use old contents
        begin
            logic h, io; logic [AW-1:0] xa;
            expect_of(32'h0001_0040, h, xa, io);
            @(negedge clk);
            cfg_we = 1; cfg_win = 3'd2; cfg_field = 2'd3; cfg_data = 32'h0;
            req_valid = 1; req_addr = 32'h0001_0040;
            @(negedge clk);
            cfg_we = 0; req_valid = 0;
            model_write(2, 3, 32'h0);
            check("R9 same-cycle old hit", AW'(rsp_hit), AW'(h));
            check("R9 same-cycle old addr", rsp_addr, xa);
        end
        lookup(32'h0001_0040, "R9 next cycle new");

        // Random phase
        for (int r = 0; r < 40; r++) begin
            for (int w = 0; w < NWIN; w++)
                set_win(w, $urandom & 32'h000F_FFFF, 3 + ($urandom % 14),
                        $urandom, ($urandom % 4) != 0, $urandom % 2);
            for (int q = 0; q < 30; q++) begin
                int w;
                logic [AW-1:0] a;
                w = $urandom % NWIN;
                case ($urandom % 4)
                    0: a = m_base[w] + ($urandom & (m_high[w] - m_base[w]));
                    1: a = m_high[w] + ($urandom % 2);
                    2: a = m_base[w] - ($urandom % 2);
                    default: a = $urandom & 32'h001F_FFFF;
                endcase
                lookup(a, "R2 R3 R4 R5 R6 random");
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule